// File: doc/BRIEF.md
# SIMD/MIMD Mode Switch Sequencer

This controller moves a processor array between lockstep SIMD operation and MIMD operation, in which each group of four processing elements is fused into one independent processing unit (a 32-element array would give 8 units). A control processor drives it with one command at a time. The commands are: configure, fill instruction caches, fill data caches, start, stop and return. The block keeps a small state machine for every unit. It drives the per-unit enable, the start pulses with a shared start program counter, the per-unit memory bases and a broadcast cache-fill request. It also reports the current mode.

The switch into MIMD follows a strict order. A three-cycle configure step selects the units and gives each selected unit its own memory window. Optional fills then load one image into several selected caches at once. A start command sets the chosen units running. The way back to SIMD is a single one-cycle command. It is honoured only once every enabled unit has finished and has reported its data cache written back. While the block is busy, any command presented is dropped.

Top module: `mode_switch_seq`

## Requirements
- R1: After reset, mimd_mode=0, busy=0, cmd_err=0, fill_req=0, unit_en=0, unit_go=0, start_pc=0, all unit_base slices are 0 and every unit_state slice is Idle (2'b00).
- R2: Configure (cmd_op=1), when accepted in SIMD mode, makes busy high for exactly the next three cycles. From the next cycle it sets unit_en=cmd_mask, and it sets unit_base slice i to cmd_base + i*2^SPAN_LG for selected units and to 0 for the others. Configure in MIMD mode is dropped.
- R3: A fill (cmd_op=2 instruction, cmd_op=3 data) is accepted once configure has completed, when the mask is nonzero and lies within unit_en. In the next cycle fill_req=1, fill_mask=cmd_mask and fill_is_data=(cmd_op==3). fill_req and busy stay high until the cycle after fill_done is seen high.
- R4: Start (cmd_op=4), when accepted under the same mask rule, moves each selected Idle or Stop unit to Run (2'b01) and pulses its unit_go bit for one cycle. It also loads start_pc with cmd_pc and sets mimd_mode=1, all in the next cycle.
- R5: A fill or start issued before configure has completed, with a zero mask, or with a mask bit outside unit_en, changes nothing else and sets cmd_err, which stays set until reset.
- R6: A Run unit whose unit_term bit is high moves to Finish (2'b11) in the next cycle. A stop addressed to the same unit in the same cycle loses.
- R7: Stop (cmd_op=5) moves each selected Run unit to Stop (2'b10) and leaves units in other states unchanged.
- R8: Return (cmd_op=6) is accepted only in MIMD mode when every enabled unit is in Finish with its unit_wb_done bit high. In the next cycle mimd_mode=0, unit_en=0 and every unit is Idle. Otherwise it is dropped.
- R9: Any command presented while busy is high is dropped.
- R10: Command codes 0 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_mask | input | NU | Unit select mask |
| cmd_pc | input | PC_W | Start program counter |
| cmd_base | input | AW | Memory base for configure |
| cmd_err | output | 1 | Sticky illegal-command flag |
| unit_term | input | NU | Per-unit terminate indication |
| unit_wb_done | input | NU | Per-unit data cache written back |
| fill_done | input | 1 | Broadcast fill complete |
| busy | output | 1 | Commands are being stalled |
| mimd_mode | output | 1 | 1 in MIMD mode, 0 in SIMD mode |
| unit_en | output | NU | Per-unit enable |
| unit_go | output | NU | Per-unit start pulse |
| start_pc | output | PC_W | Start program counter for started units |
| unit_base | output | NU*AW | Per-unit memory base, unit i in bits i*AW +: AW |
| fill_req | output | 1 | Broadcast fill in progress |
| fill_is_data | output | 1 | 1 for a data fill, 0 for an instruction fill |
| fill_mask | output | NU | Units receiving the fill |
| unit_state | output | 2*NU | Per-unit state, unit i in bits 2*i +: 2 |

## Verification
The sharpest collision is a unit raising its terminate input in the same cycle that a stop command names it. Terminate must win and the unit must land in Finish, not Stop. A directed case provokes this, and the random stream hits it repeatedly by mixing stop commands with random terminate bits. A second collision is a return issued in the cycle a unit terminates. Because the gate uses the state registered before that edge, the return must be dropped. A bench reference model judges both cases, since it updates state from the old values and applies return last.

// File: rtl/mode_switch_seq.sv
module mode_switch_seq #(
  parameter int NU      = 8,
  parameter int PC_W    = 16,
  parameter int AW      = 16,
  parameter int SPAN_LG = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [NU-1:0]     cmd_mask,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic [AW-1:0]     cmd_base,
  output logic              cmd_err,
  input  logic [NU-1:0]     unit_term,
  input  logic [NU-1:0]     unit_wb_done,
  input  logic              fill_done,
  output logic              busy,
  output logic              mimd_mode,
  output logic [NU-1:0]     unit_en,
  output logic [NU-1:0]     unit_go,
  output logic [PC_W-1:0]   start_pc,
  output logic [NU*AW-1:0]  unit_base,
  output logic              fill_req,
  output logic              fill_is_data,
  output logic [NU-1:0]     fill_mask,
  output logic [2*NU-1:0]   unit_state
);
  localparam logic [1:0] S_IDLE = 2'b00, S_RUN = 2'b01, S_STOP = 2'b10, S_FIN = 2'b11;

  logic [1:0] icnt;
  logic inited;
  logic [NU-1:0] rdy_vec, done_vec;

  always_comb begin
    for (int i = 0; i < NU; i++) begin
      rdy_vec[i]  = (unit_state[2*i +: 2] == S_IDLE) || (unit_state[2*i +: 2] == S_STOP);
      done_vec[i] = !unit_en[i] || ((unit_state[2*i +: 2] == S_FIN) && unit_wb_done[i]);
    end
  end

  assign busy = (icnt != 2'd0) || fill_req;

  wire acc      = cmd_valid && !busy;
  wire mask_ok  = inited && (cmd_mask != '0) && ((cmd_mask & ~unit_en) == '0);
  wire op_init  = acc && (cmd_op == 3'd1) && !mimd_mode;
  wire op_fill  = acc && ((cmd_op == 3'd2) || (cmd_op == 3'd3));
  wire op_start = acc && (cmd_op == 3'd4);
  wire op_stop  = acc && (cmd_op == 3'd5);
  wire ret_ok   = acc && (cmd_op == 3'd6) && mimd_mode && (&done_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt <= '0; inited <= 1'b0; mimd_mode <= 1'b0; cmd_err <= 1'b0;
      unit_en <= '0; unit_go <= '0; start_pc <= '0; unit_base <= '0;
      fill_req <= 1'b0; fill_is_data <= 1'b0; fill_mask <= '0; unit_state <= '0;
    end else begin
      unit_go <= '0;
      if (icnt != 2'd0) icnt <= icnt - 2'd1;
      if (icnt == 2'd1) inited <= 1'b1;
      if (fill_req && fill_done) fill_req <= 1'b0;

      if (op_init) begin
        icnt    <= 2'd3;
        inited  <= 1'b0;
        unit_en <= cmd_mask;
        for (int i = 0; i < NU; i++)
          unit_base[i*AW +: AW] <= cmd_mask[i] ? cmd_base + AW'(i << SPAN_LG) : '0;
      end

      if (op_fill) begin
        if (mask_ok) begin
          fill_req     <= 1'b1;
          fill_is_data <= cmd_op[0];
          fill_mask    <= cmd_mask;
        end else cmd_err <= 1'b1;
      end

      if (op_start) begin
        if (mask_ok) begin
          mimd_mode <= 1'b1;
          start_pc  <= cmd_pc;
          unit_go   <= cmd_mask & rdy_vec;
        end else cmd_err <= 1'b1;
      end

      for (int i = 0; i < NU; i++) begin
        case (unit_state[2*i +: 2])
          S_IDLE:  if (op_start && mask_ok && cmd_mask[i]) unit_state[2*i +: 2] <= S_RUN;
          S_STOP:  if (op_start && mask_ok && cmd_mask[i]) unit_state[2*i +: 2] <= S_RUN;
          S_RUN:   if (unit_term[i]) unit_state[2*i +: 2] <= S_FIN;
                   else if (op_stop && cmd_mask[i]) unit_state[2*i +: 2] <= S_STOP;
          default: ;
        endcase
      end

      if (ret_ok) begin
        mimd_mode  <= 1'b0;
        unit_en    <= '0;
        inited     <= 1'b0;
        unit_state <= '0;
      end
    end
  end
endmodule

// File: rtl/mode_switch_seq_chk.sv
module mode_switch_seq_chk #(
  parameter int NU = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_op,
  input logic            busy,
  input logic            mimd_mode,
  input logic            cmd_err,
  input logic [NU-1:0]   unit_en,
  input logic [NU-1:0]   unit_go,
  input logic [NU-1:0]   unit_wb_done,
  input logic [2*NU-1:0] unit_state,
  input logic            fill_req,
  input logic [NU-1:0]   fill_mask
);
  logic done_all;
  always_comb begin
    done_all = 1'b1;
    for (int i = 0; i < NU; i++)
      if (unit_en[i] && !((unit_state[2*i +: 2] == 2'b11) && unit_wb_done[i])) done_all = 1'b0;
  end

  p_init_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd1 && !mimd_mode) |=> busy ##1 busy ##1 busy ##1 !busy);

  p_fill_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> ((fill_mask & ~unit_en) == '0));

  p_go_mimd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_go != '0) |-> mimd_mode);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  p_ret_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mimd_mode) |-> $past(done_all));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(unit_en));
endmodule

bind mode_switch_seq mode_switch_seq_chk #(.NU(NU)) u_chk (.*);

// File: tb/tb_mode_switch_seq.sv
module tb_mode_switch_seq;
  localparam int NU = 8, PC_W = 16, AW = 16, SPAN_LG = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, fill_done = 0;
  logic [2:0] cmd_op = 0;
  logic [NU-1:0] cmd_mask = 0, unit_term = 0, unit_wb_done = 0;
  logic [PC_W-1:0] cmd_pc = 0;
  logic [AW-1:0] cmd_base = 0;
  logic cmd_err, busy, mimd_mode, fill_req, fill_is_data;
  logic [NU-1:0] unit_en, unit_go, fill_mask;
  logic [PC_W-1:0] start_pc;
  logic [NU*AW-1:0] unit_base;
  logic [2*NU-1:0] unit_state;

  mode_switch_seq #(.NU(NU), .PC_W(PC_W), .AW(AW), .SPAN_LG(SPAN_LG)) dut (.*);

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 0;

  logic [1:0] m_icnt; logic m_inited, m_mode, m_err, m_freq, m_fdata;
  logic [NU-1:0] m_en, m_go, m_fmask;
  logic [PC_W-1:0] m_pc;
  logic [NU*AW-1:0] m_base;
  logic [2*NU-1:0] m_st;

  task automatic mreset();
    m_icnt = 0; m_inited = 0; m_mode = 0; m_err = 0; m_freq = 0; m_fdata = 0;
    m_en = 0; m_go = 0; m_fmask = 0; m_pc = 0; m_base = 0; m_st = 0;
  endtask

  task automatic chk(string req, string what, logic [127:0] got, logic [127:0] exp);
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic compare_all();
    vecs++;
    chk("R2/R3/R9", "busy", busy, (m_icnt != 0) || m_freq);
    chk("R4/R8", "mimd_mode", mimd_mode, m_mode);
    chk("R2/R8", "unit_en", unit_en, m_en);
    chk("R4/R6/R7/R8", "unit_state", unit_state, m_st);
    chk("R5", "cmd_err", cmd_err, m_err);
    chk("R3", "fill_req", fill_req, m_freq);
    chk("R3", "fill_mask", fill_mask, m_fmask);
    chk("R3", "fill_is_data", fill_is_data, m_fdata);
    chk("R4", "unit_go", unit_go, m_go);
    chk("R4", "start_pc", start_pc, m_pc);
    chk("R2", "unit_base", unit_base, m_base);
  endtask

  task automatic mstep();
    logic b, acc, mok, alld;
    logic [2*NU-1:0] ns;
    b = (m_icnt != 0) || m_freq;
    acc = cmd_valid && !b;
    mok = m_inited && (cmd_mask != 0) && ((cmd_mask & ~m_en) == 0);
    alld = 1;
    for (int i = 0; i < NU; i++)
      if (m_en[i] && !(m_st[2*i +: 2] == 2'b11 && unit_wb_done[i])) alld = 0;
    ns = m_st;
    for (int i = 0; i < NU; i++)
      if (m_st[2*i +: 2] == 2'b01 && unit_term[i]) ns[2*i +: 2] = 2'b11;
    m_go = 0;
    if (m_icnt == 1) m_inited = 1;
    if (m_icnt != 0) m_icnt = m_icnt - 1;
    if (m_freq && fill_done) m_freq = 0;
    if (acc) begin
      case (cmd_op)
        3'd1: if (!m_mode) begin
          m_icnt = 3; m_inited = 0; m_en = cmd_mask;
          for (int i = 0; i < NU; i++)
            m_base[i*AW +: AW] = cmd_mask[i] ? cmd_base + AW'(i * (1 << SPAN_LG)) : '0;
        end
        3'd2, 3'd3: if (mok) begin m_freq = 1; m_fdata = (cmd_op == 3'd3); m_fmask = cmd_mask; end
                    else m_err = 1;
        3'd4: if (mok) begin
          m_mode = 1; m_pc = cmd_pc;
          for (int i = 0; i < NU; i++)
            if (cmd_mask[i] && (m_st[2*i +: 2] == 2'b00 || m_st[2*i +: 2] == 2'b10)) begin
              m_go[i] = 1; ns[2*i +: 2] = 2'b01;
            end
        end else m_err = 1;
        3'd5: for (int i = 0; i < NU; i++)
          if (cmd_mask[i] && m_st[2*i +: 2] == 2'b01 && !unit_term[i]) ns[2*i +: 2] = 2'b10;
        3'd6: if (m_mode && alld) begin m_mode = 0; m_en = 0; m_inited = 0; ns = 0; end
        default: ;
      endcase
    end
    m_st = ns;
  endtask

  task automatic cyc(logic v, logic [2:0] op, logic [NU-1:0] mk, logic [PC_W-1:0] pc,
                     logic [AW-1:0] base, logic [NU-1:0] term, logic [NU-1:0] wb, logic fd);
    cmd_valid = v; cmd_op = op; cmd_mask = mk; cmd_pc = pc; cmd_base = base;
    unit_term = term; unit_wb_done = wb; fill_done = fd;
    mstep();
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    cmd_valid = 0; unit_term = 0; fill_done = 0;
    rst_n = 0; mreset();
    @(posedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(5 * 190000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    @(negedge clk);
    do_reset();
    // R1 reset state
    compare_all();
    // R5 start before configure
    cyc(1, 3'd4, 8'h01, 16'h10, 0, 0, 0, 0);
    chk("R5", "err after early start", cmd_err, 1);
    do_reset();
    // R10 unused code, R2 configure, R9 command during busy
    cyc(1, 3'd7, 8'hff, 0, 0, 0, 0, 0);
    cyc(1, 3'd1, 8'h05, 0, 16'h0100, 0, 0, 0);
    cyc(1, 3'd2, 8'h01, 0, 0, 0, 0, 0);
    chk("R9", "fill while busy dropped", fill_req, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "busy released", busy, 0);
    // R3 data fill with delayed completion
    cyc(1, 3'd3, 8'h05, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R3", "fill ended", fill_req, 0);
    // R4 start
    cyc(1, 3'd4, 8'h05, 16'h0040, 0, 0, 0, 0);
    chk("R4", "mode", mimd_mode, 1);
    // R6 terminate unit0; R6/R7 stop and terminate on unit2 together
    cyc(1, 3'd5, 8'h04, 0, 0, 8'h05, 0, 0);
    chk("R6", "unit2 finish wins", unit_state[5:4], 2'b11);
    // R8 return without write-back dropped, then accepted
    cyc(1, 3'd6, 0, 0, 0, 0, 8'h00, 0);
    chk("R8", "return gated", mimd_mode, 1);
    cyc(1, 3'd6, 0, 0, 0, 0, 8'hff, 0);
    chk("R8", "return taken", mimd_mode, 0);
    // random segments
    for (int s = 0; s < 40; s++) begin
      do_reset();
      for (int n = 0; n < 200; n++) begin
        logic [2:0] op;
        logic [NU-1:0] mk;
        op = 3'($urandom_range(0, 7));
        mk = ($urandom_range(0, 3) != 0) ? (m_en & NU'($urandom)) : NU'($urandom);
        if ($urandom_range(0, 9) == 0) mk = 0;
        cyc($urandom_range(0, 2) != 0, op, mk, 16'($urandom), 16'($urandom),
            ($urandom_range(0, 3) == 0) ? NU'($urandom) : '0,
            ($urandom_range(0, 3) != 0) ? '1 : NU'($urandom), $urandom_range(0, 1) == 1);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule